// File: doc/BRIEF.md
# Triggered Command Set Sequencer

This block holds a small number of command sets. Each set owns a fixed number of command slots. Every slot stores three words: a message descriptor, a target address and a data word. Software fills the slots over a simple memory-mapped bus and selects the slots it wants with a per-set mask. It then arms the set and fires it. A single shared engine sends the selected commands downstream in ascending slot order over a valid/ready request port. A command that asks for a response waits for one on a response strobe before the engine moves on.

For each slot the block records whether the command went out and whether it finished. Response data is captured in the slot. When a set has finished, the block raises that set's bit in an interrupt status word. The interrupt line is driven from the status bits that are enabled. While a set is queued or running, its control word, mask and slots are frozen against bus writes. If several sets are queued at once, they are served one at a time, lowest index first.

Top module: `cmdset_seq`

## Requirements
- R1: After reset, every set's idle word reads 1, the interrupt status reads 0, `irq` is 0 and `cmd_valid` is 0.
- R2: Set s occupies addresses 672*s+o for offsets o from 0x10 to 671. The control word is at o=0x14, the idle word at 0x18 and the slot mask at 0x1C, with slot k enabled by mask bit k. Slot k's words sit at o=0x30+20*k+f, with f=0 for the descriptor, 4 for the address, 8 for the data, 12 for the status and 16 for the response data. Descriptor, address, data, mask and control read back what was last written to them.
- R3: The control word holds arm at bit 16 and fire at bit 24. A write launches the set only if the stored arm bit is already 1, the stored fire bit is 0, and the written fire bit is 1. A single write that sets arm and fire together from zero does not launch.
- R4: A launched set sends each slot whose mask bit is set, in ascending slot order. Each command carries the slot's address and data. `cmd_write` copies descriptor bit 16 and `cmd_need_rsp` copies descriptor bit 8. A set with an empty mask finishes without sending anything.
- R5: The idle word at 0x18 reads 0 from the cycle after launch until the set has finished, and reads 1 otherwise.
- R6: Slot status bit 8 means the command was sent and bit 16 means it is complete. Launching a set clears the status of all its slots. A command without bit 8 set in its descriptor completes when it is accepted. A command with bit 8 set completes only when `rsp_valid` arrives, and `rsp_data` is stored in that slot's response word.
- R7: Global registers below 0x10: the interrupt enable is at 0x00 and the interrupt status at 0x04, one bit per set. Writing 1s to 0x08 clears the matching status bits. A set's status bit is set when it finishes. `irq` is the OR of status ANDed with enable.
- R8: Writes to the control word, mask or slot words of a queued or running set have no effect.
- R9: Once a set has finished, it is re-armed by clearing fire and then arm. Arming and firing it again launches a new transfer. Writing fire=1 again while the stored fire is already 1 does not launch.
- R10: Sets queued together are served one at a time, in ascending set index order.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and `cmd_addr` and `cmd_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_addr | output | 32 | Command target address |
| cmd_data | output | 32 | Command data word |
| cmd_write | output | 1 | Write flag from descriptor |
| cmd_need_rsp | output | 1 | Response-required flag from descriptor |
| rsp_valid | input | 1 | Response strobe for the outstanding command |
| rsp_data | input | 32 | Response data |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that `rsp_valid` pulses only while a response-required command is outstanding, and only once per such command. They also assume that bus writes hit only the registers of the address map. The bench's downstream model arms a response only after it has accepted a command that has `cmd_need_rsp` set. It then delivers that response exactly once after a random delay. Every bus address it uses comes from its own map functions.

// File: rtl/cmdset_seq_pkg.sv
package cmdset_seq_pkg;
  localparam int SET_STRIDE  = 672;
  localparam int SLOT_BASE   = 48;
  localparam int SLOT_STRIDE = 20;
  localparam int GLOBAL_SPAN = 16;
  localparam int R_IRQ_EN    = 0;
  localparam int R_IRQ_STAT  = 4;
  localparam int R_IRQ_CLR   = 8;
  localparam int R_CTRL      = 20;
  localparam int R_IDLE      = 24;
  localparam int R_CMDEN     = 28;
  localparam int F_MSG       = 0;
  localparam int F_ADDR      = 4;
  localparam int F_DATA      = 8;
  localparam int F_STAT      = 12;
  localparam int F_RESP      = 16;
  localparam int B_ARM       = 16;
  localparam int B_FIRE      = 24;
  localparam int B_NEEDRSP   = 8;
  localparam int B_WRITE     = 16;
  localparam int B_ISSUED    = 8;
  localparam int B_DONE      = 16;

  typedef enum logic [1:0] {ENG_IDLE, ENG_SCAN, ENG_REQ, ENG_RSP} eng_state_e;

  function automatic int set_of(int a);
    return a / SET_STRIDE;
  endfunction

  function automatic int ofs_of(int a);
    return a % SET_STRIDE;
  endfunction

  function automatic int slot_of(int ofs);
    return (ofs - SLOT_BASE) / SLOT_STRIDE;
  endfunction

  function automatic int field_of(int ofs);
    return (ofs - SLOT_BASE) % SLOT_STRIDE;
  endfunction

  function automatic logic [31:0] ctrl_word(logic arm, logic fire);
    return (32'(fire) << B_FIRE) | (32'(arm) << B_ARM);
  endfunction

  function automatic logic [31:0] slot_word(logic issued, logic done);
    return (32'(done) << B_DONE) | (32'(issued) << B_ISSUED);
  endfunction
endpackage

// File: rtl/cmdset_pick.sv
module cmdset_pick #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  output logic         valid,
  output logic [W-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/cmdset_engine.sv
module cmdset_engine
  import cmdset_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SET_W     = 2,
  parameter int SLOT_IW   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pick_valid,
  input  logic [SET_W-1:0]     pick_set,
  input  logic [NUM_SLOTS-1:0] cur_en,
  input  logic                 cur_need_rsp,
  input  logic                 cmd_ready,
  input  logic                 rsp_valid,
  output eng_state_e           state,
  output logic [SET_W-1:0]     cur_set,
  output logic [SLOT_IW-1:0]   cur_idx,
  output logic                 cmd_valid,
  output logic                 take,
  output logic                 accept_ev,
  output logic                 rsp_ev,
  output logic                 done_ev,
  output logic                 active
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  logic [CNT_W-1:0] pos_q;
  logic             slot_on;

  function automatic logic at_end(logic [CNT_W-1:0] p);
    return int'(p) >= NUM_SLOTS;
  endfunction

  assign cur_idx   = pos_q[SLOT_IW-1:0];
  assign slot_on   = !at_end(pos_q) && cur_en[cur_idx];
  assign cmd_valid = (state == ENG_REQ);
  assign take      = (state == ENG_IDLE) && pick_valid;
  assign accept_ev = cmd_valid && cmd_ready;
  assign rsp_ev    = (state == ENG_RSP) && rsp_valid;
  assign done_ev   = (state == ENG_SCAN) && at_end(pos_q);
  assign active    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      cur_set <= '0;
      pos_q   <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (pick_valid) begin
          cur_set <= pick_set;
          pos_q   <= '0;
          state   <= ENG_SCAN;
        end
        ENG_SCAN: begin
          if (at_end(pos_q))  state <= ENG_IDLE;
          else if (slot_on)   state <= ENG_REQ;
          else                pos_q <= pos_q + 1'b1;
        end
        ENG_REQ: if (cmd_ready) begin
          if (cur_need_rsp) state <= ENG_RSP;
          else begin
            pos_q <= pos_q + 1'b1;
            state <= ENG_SCAN;
          end
        end
        ENG_RSP: if (rsp_valid) begin
          pos_q <= pos_q + 1'b1;
          state <= ENG_SCAN;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdset_seq.sv
module cmdset_seq
  import cmdset_seq_pkg::*;
#(
  parameter int NUM_SETS  = 3,
  parameter int NUM_SLOTS = 4,
  parameter int BUS_AW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_addr,
  output logic [31:0]       cmd_data,
  output logic              cmd_write,
  output logic              cmd_need_rsp,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              irq
);
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  // storage
  logic [31:0]          msg_q  [NUM_SETS][NUM_SLOTS];
  logic [31:0]          addr_q [NUM_SETS][NUM_SLOTS];
  logic [31:0]          data_q [NUM_SETS][NUM_SLOTS];
  logic [31:0]          rsp_q  [NUM_SETS][NUM_SLOTS];
  logic [NUM_SLOTS-1:0] issued_q [NUM_SETS];
  logic [NUM_SLOTS-1:0] done_q   [NUM_SETS];
  logic [NUM_SLOTS-1:0] cmden_q  [NUM_SETS];
  logic [NUM_SETS-1:0]  arm_q, fire_q, pend_q, irq_en_q, irq_st_q;

  // named events
  logic [NUM_SETS-1:0] busy_vec, launch_vec;
  logic [NUM_SETS-1:0] clr_mask, done_mask;
  eng_state_e          eng_state;
  logic [SET_W-1:0]    eng_set, pick_set;
  logic [SLOT_IW-1:0]  eng_idx;
  logic                pick_valid, eng_take, eng_accept, eng_rsp, eng_done, eng_active;
  logic                cur_need_rsp;

  // address decode
  int                 a_int, a_set, a_ofs, a_slot, a_fld;
  logic               is_glob, set_ok, is_slot, sel_busy, wr_set_ok;
  logic [SET_W-1:0]   sel_set;
  logic [SLOT_IW-1:0] sel_slot;

  always_comb begin
    a_int    = int'(bus_addr);
    a_set    = set_of(a_int);
    a_ofs    = ofs_of(a_int);
    a_slot   = slot_of(a_ofs);
    a_fld    = field_of(a_ofs);
    is_glob  = a_int < GLOBAL_SPAN;
    set_ok   = !is_glob && (a_set < NUM_SETS);
    is_slot  = (a_ofs >= SLOT_BASE) && (a_slot < NUM_SLOTS);
    sel_set  = a_set[SET_W-1:0];
    sel_slot = a_slot[SLOT_IW-1:0];
    sel_busy = set_ok && busy_vec[sel_set];
    wr_set_ok = bus_sel && bus_wr && set_ok && !sel_busy;
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    assign busy_vec[g]   = pend_q[g] | (eng_active && (eng_set == SET_W'(g)));
    assign launch_vec[g] = wr_set_ok && (sel_set == SET_W'(g)) && (a_ofs == R_CTRL)
                           && arm_q[g] && !fire_q[g] && bus_wdata[B_FIRE];
    assign done_mask[g]  = eng_done && (eng_set == SET_W'(g));
  end

  assign clr_mask = (bus_sel && bus_wr && is_glob && a_int == R_IRQ_CLR)
                    ? bus_wdata[NUM_SETS-1:0] : '0;

  cmdset_pick #(.N(NUM_SETS), .W(SET_W)) pick_i (
    .req(pend_q), .valid(pick_valid), .idx(pick_set)
  );

  cmdset_engine #(.NUM_SLOTS(NUM_SLOTS), .SET_W(SET_W), .SLOT_IW(SLOT_IW)) eng_i (
    .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_set(pick_set),
    .cur_en(cmden_q[eng_set]), .cur_need_rsp(cur_need_rsp),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .state(eng_state),
    .cur_set(eng_set), .cur_idx(eng_idx), .cmd_valid(cmd_valid), .take(eng_take),
    .accept_ev(eng_accept), .rsp_ev(eng_rsp), .done_ev(eng_done), .active(eng_active)
  );

  assign cur_need_rsp = msg_q[eng_set][eng_idx][B_NEEDRSP];
  assign cmd_need_rsp = cur_need_rsp;
  assign cmd_write    = msg_q[eng_set][eng_idx][B_WRITE];
  assign cmd_addr     = addr_q[eng_set][eng_idx];
  assign cmd_data     = data_q[eng_set][eng_idx];
  assign irq          = |(irq_st_q & irq_en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q <= '0; fire_q <= '0; pend_q <= '0; irq_en_q <= '0; irq_st_q <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        issued_q[s] <= '0; done_q[s] <= '0; cmden_q[s] <= '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
          msg_q[s][k] <= '0; addr_q[s][k] <= '0; data_q[s][k] <= '0; rsp_q[s][k] <= '0;
        end
      end
    end else begin
      if (bus_sel && bus_wr && is_glob && a_int == R_IRQ_EN)
        irq_en_q <= bus_wdata[NUM_SETS-1:0];
      if (wr_set_ok) begin
        if (a_ofs == R_CTRL) begin
          arm_q[sel_set]  <= bus_wdata[B_ARM];
          fire_q[sel_set] <= bus_wdata[B_FIRE];
        end
        if (a_ofs == R_CMDEN) cmden_q[sel_set] <= bus_wdata[NUM_SLOTS-1:0];
        if (is_slot) begin
          case (a_fld)
            F_MSG:   msg_q[sel_set][sel_slot]  <= bus_wdata;
            F_ADDR:  addr_q[sel_set][sel_slot] <= bus_wdata;
            F_DATA:  data_q[sel_set][sel_slot] <= bus_wdata;
            default: ;
          endcase
        end
      end
      for (int s = 0; s < NUM_SETS; s++) begin
        if (launch_vec[s]) begin
          pend_q[s]   <= 1'b1;
          issued_q[s] <= '0;
          done_q[s]   <= '0;
        end
      end
      if (eng_take) pend_q[pick_set] <= 1'b0;
      if (eng_accept) begin
        issued_q[eng_set][eng_idx] <= 1'b1;
        if (!cur_need_rsp) done_q[eng_set][eng_idx] <= 1'b1;
      end
      if (eng_rsp) begin
        rsp_q[eng_set][eng_idx]  <= rsp_data;
        done_q[eng_set][eng_idx] <= 1'b1;
      end
      irq_st_q <= (irq_st_q & ~clr_mask) | done_mask;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_glob) begin
      if (a_int == R_IRQ_EN)   bus_rdata = 32'(irq_en_q);
      if (a_int == R_IRQ_STAT) bus_rdata = 32'(irq_st_q);
    end else if (set_ok) begin
      if (a_ofs == R_CTRL)  bus_rdata = ctrl_word(arm_q[sel_set], fire_q[sel_set]);
      if (a_ofs == R_IDLE)  bus_rdata = 32'(!busy_vec[sel_set]);
      if (a_ofs == R_CMDEN) bus_rdata = 32'(cmden_q[sel_set]);
      if (is_slot) begin
        case (a_fld)
          F_MSG:   bus_rdata = msg_q[sel_set][sel_slot];
          F_ADDR:  bus_rdata = addr_q[sel_set][sel_slot];
          F_DATA:  bus_rdata = data_q[sel_set][sel_slot];
          F_STAT:  bus_rdata = slot_word(issued_q[sel_set][sel_slot], done_q[sel_set][sel_slot]);
          F_RESP:  bus_rdata = rsp_q[sel_set][sel_slot];
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdset_seq_chk.sv
module cmdset_seq_chk #(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [31:0]         cmd_addr,
  input logic [31:0]         cmd_data,
  input logic [NUM_SETS-1:0] busy_vec,
  input logic [NUM_SETS-1:0] launch_vec,
  input logic [NUM_SETS-1:0] arm_vec,
  input logic [NUM_SETS-1:0] fire_vec,
  input logic                done_ev,
  input logic [SET_W-1:0]    done_set,
  input logic                irq,
  input logic                bus_sel,
  input logic                bus_wr
);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_vec != '0) |=> ((busy_vec & $past(launch_vec)) == $past(launch_vec)));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy_vec[$past(done_set)]);

  // R8
  frozen_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((arm_vec ^ $past(arm_vec)) | (fire_vec ^ $past(fire_vec))) & busy_vec & $past(busy_vec)) == '0);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(done_ev) || $past(bus_sel && bus_wr)));
endmodule

bind cmdset_seq cmdset_seq_chk #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy_vec(busy_vec),
  .launch_vec(launch_vec), .arm_vec(arm_q), .fire_vec(fire_q),
  .done_ev(eng_done), .done_set(eng_set), .irq(irq),
  .bus_sel(bus_sel), .bus_wr(bus_wr)
);

// File: tb/cmdset_seq_tb_top.sv
module cmdset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 3;
  localparam int NSLOTS = 4;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cmd_valid, cmd_ready = 0, cmd_write, cmd_need_rsp, rsp_valid = 0, irq;
  logic [31:0] cmd_addr, cmd_data, rsp_data = '0;

  int checks = 0, fails = 0;
  bit hold_ready = 0, hold_rsp = 0, rsp_pend = 0;
  int rsp_wait = 0;
  logic [31:0] rsp_addr = '0;
  logic [31:0] log_addr[$], log_data[$];
  bit log_wr[$], log_rsp[$];

  logic [31:0] e_msg[NSETS][NSLOTS], e_addr[NSETS][NSLOTS], e_data[NSETS][NSLOTS];
  logic [NSLOTS-1:0] e_mask[NSETS];

  cmdset_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_write(cmd_write), .cmd_need_rsp(cmd_need_rsp), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int reg_at(int s, int o); return 672 * s + o; endfunction
  function automatic int slot_at(int s, int k, int f); return 672 * s + 48 + 20 * k + f; endfunction
  function automatic logic [31:0] rsp_of(logic [31:0] a); return {a[15:0], ~a[31:16]}; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 12'(a);
    #1 d = bus_rdata; bus_sel = 0;
  endtask

  // downstream model
  always @(negedge clk) cmd_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
  always @(posedge clk) if (rst_n && cmd_valid && cmd_ready) begin
    log_addr.push_back(cmd_addr); log_data.push_back(cmd_data);
    log_wr.push_back(cmd_write);  log_rsp.push_back(cmd_need_rsp);
    if (cmd_need_rsp) begin rsp_pend = 1; rsp_wait = $urandom % 4; rsp_addr = cmd_addr; end
  end
  always @(negedge clk) begin
    rsp_valid = 0;
    if (rsp_pend && !hold_rsp) begin
      if (rsp_wait == 0) begin rsp_valid = 1; rsp_data = rsp_of(rsp_addr); rsp_pend = 0; end
      else rsp_wait--;
    end
  end

  task automatic prog_set(int s, logic [NSLOTS-1:0] mask);
    for (int k = 0; k < NSLOTS; k++) begin
      e_msg[s][k]  = {15'b0, 1'($urandom), 7'b0, 1'($urandom), 8'($urandom % 8 + 1)};
      e_addr[s][k] = {8'(s), 8'(k), 16'($urandom)};
      e_data[s][k] = $urandom;
      wr(slot_at(s, k, 0), e_msg[s][k]);
      wr(slot_at(s, k, 4), e_addr[s][k]);
      wr(slot_at(s, k, 8), e_data[s][k]);
    end
    e_mask[s] = mask;
    wr(reg_at(s, 28), 32'(mask));
  endtask

  task automatic arm(int s);
    wr(reg_at(s, 20), 32'h0001_0000);
    wr(reg_at(s, 20), 32'h0101_0000);
  endtask

  task automatic disarm(int s);
    wr(reg_at(s, 20), 32'h0001_0000);
    wr(reg_at(s, 20), 32'h0000_0000);
  endtask

  task automatic wait_idle(int s);
    logic [31:0] v;
    int n = 0;
    do begin rd(reg_at(s, 24), v); n++; end while (v != 1 && n < 3000);
  endtask

  task automatic verify_set(int s);
    logic [31:0] v;
    for (int k = 0; k < NSLOTS; k++) begin
      if (e_mask[s][k]) begin
        if (log_addr.size() == 0) chk("R4 missing command", 32'(k), 32'hFFFF_FFFF);
        else begin
          chk("R4 addr order", log_addr.pop_front(), e_addr[s][k]);
          chk("R4 data", log_data.pop_front(), e_data[s][k]);
          chk("R4 write flag", 32'(log_wr.pop_front()), 32'(e_msg[s][k][16]));
          chk("R4 rsp flag", 32'(log_rsp.pop_front()), 32'(e_msg[s][k][8]));
        end
      end
    end
    for (int k = 0; k < NSLOTS; k++) begin
      rd(slot_at(s, k, 12), v);
      chk("R6 slot status", v, e_mask[s][k] ? 32'h0001_0100 : 32'h0);
      if (e_mask[s][k] && e_msg[s][k][8]) begin
        rd(slot_at(s, k, 16), v);
        chk("R6 response data", v, rsp_of(e_addr[s][k]));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < NSETS; s++) begin rd(reg_at(s, 24), v); chk("R1 idle", v, 1); end
    rd(4, v); chk("R1 irq status", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cmd_valid", 32'(cmd_valid), 0);

    // R2 map readback
    wr(slot_at(1, 3, 0), 32'h0001_0102); rd(slot_at(1, 3, 0), v); chk("R2 descriptor", v, 32'h0001_0102);
    wr(slot_at(1, 3, 4), 32'h1234_5678); rd(slot_at(1, 3, 4), v); chk("R2 address", v, 32'h1234_5678);
    wr(slot_at(1, 3, 8), 32'hCAFE_F00D); rd(slot_at(1, 3, 8), v); chk("R2 data", v, 32'hCAFE_F00D);
    wr(reg_at(1, 28), 32'hFFFF_FFFA);    rd(reg_at(1, 28), v);    chk("R2 mask", v, 32'h0000_000A);
    wr(reg_at(1, 20), 32'h0001_0000);    rd(reg_at(1, 20), v);    chk("R2 control", v, 32'h0001_0000);
    wr(reg_at(1, 20), 32'h0);

    // R3 single write does not launch; R9 re-arm
    prog_set(0, 4'b1011);
    wr(reg_at(0, 20), 32'h0101_0000);
    repeat (10) @(negedge clk);
    rd(reg_at(0, 24), v); chk("R3 no launch on joint write", v, 1);
    chk("R3 nothing sent", 32'(log_addr.size()), 0);
    wr(reg_at(0, 20), 32'h0101_0000);
    repeat (10) @(negedge clk);
    rd(reg_at(0, 24), v); chk("R9 fire held high no launch", v, 1);
    arm(0);
    rd(reg_at(0, 24), v); chk("R5 busy after launch", v, 0);
    wait_idle(0);
    verify_set(0);
    rd(4, v); chk("R7 status bit set0", v, 1);
    wr(8, 32'h7); rd(4, v); chk("R7 w1c clear", v, 0);
    disarm(0);

    // R4 empty mask
    prog_set(2, 4'b0000);
    arm(2); wait_idle(2);
    chk("R4 empty mask sends nothing", 32'(log_addr.size()), 0);
    rd(4, v); chk("R7 empty set finishes", v, 32'h4);
    wr(8, 32'h7); disarm(2);

    // R6 response-required completes only on response
    prog_set(1, 4'b0001);
    e_msg[1][0] = 32'h0000_0104;
    wr(slot_at(1, 0, 0), e_msg[1][0]);
    hold_rsp = 1;
    arm(1);
    repeat (15) @(negedge clk);
    rd(slot_at(1, 0, 12), v); chk("R6 issued not complete", v, 32'h0000_0100);
    rd(reg_at(1, 24), v); chk("R5 busy awaiting response", v, 0);
    hold_rsp = 0;
    wait_idle(1); verify_set(1);
    wr(8, 32'h7); disarm(1);

    // R8, R10, R11 queued sets with stalled downstream
    prog_set(0, 4'b0101); prog_set(1, 4'b1111); prog_set(2, 4'b0011);
    hold_ready = 1;
    arm(0);
    repeat (3) @(negedge clk);
    chk("R11 valid held", 32'(cmd_valid), 1);
    chk("R11 addr held", cmd_addr, e_addr[0][0]);
    rd(reg_at(0, 24), v); chk("R5 busy while stalled", v, 0);
    wr(slot_at(0, 0, 4), 32'hDEAD_0000);
    wr(reg_at(0, 28), 32'h0);
    wr(reg_at(0, 20), 32'h0);
    arm(2); arm(1);
    chk("R11 addr still held", cmd_addr, e_addr[0][0]);
    chk("R11 data still held", cmd_data, e_data[0][0]);
    hold_ready = 0;
    wait_idle(0); wait_idle(1); wait_idle(2);
    verify_set(0); verify_set(1); verify_set(2);   // R10 order
    chk("R10 no extra commands", 32'(log_addr.size()), 0);
    rd(slot_at(0, 0, 4), v); chk("R8 slot write ignored", v, e_addr[0][0]);
    rd(reg_at(0, 28), v);    chk("R8 mask write ignored", v, 32'h5);
    rd(reg_at(0, 20), v);    chk("R8 control write ignored", v, 32'h0101_0000);
    rd(4, v); chk("R7 all three finished", v, 32'h7);
    wr(8, 32'h7);
    for (int s = 0; s < NSETS; s++) disarm(s);

    // random mix
    for (int it = 0; it < 30; it++) begin
      int s;
      logic [NSETS-1:0] en;
      logic [NSLOTS-1:0] mask;
      s = $urandom % NSETS;
      en = NSETS'($urandom);
      mask = NSLOTS'($urandom);
      log_addr.delete(); log_data.delete(); log_wr.delete(); log_rsp.delete();
      wr(0, 32'(en));
      prog_set(s, mask);
      arm(s);
      if (mask != 0) begin rd(reg_at(s, 24), v); chk("R5 busy random", v, 0); end
      wait_idle(s);
      verify_set(s);
      rd(4, v); chk("R7 status random", v, 32'(1 << s));
      chk("R7 irq gating", 32'(irq), 32'(en[s]));
      wr(8, 32'(1 << s));
      rd(4, v); chk("R7 clear random", v, 0);
      chk("R7 irq low after clear", 32'(irq), 0);
      disarm(s);   // R9 re-arm path reused next time
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule